// File: doc/BRIEF.md
# Stereo Serial Audio Deserializer

This block takes stereo PCM audio arriving on a three-wire serial port (a word-select line, a bit clock and a data line) and turns it into a pair of parallel 18-bit signed sample words with a single-cycle strobe. Two framings are understood. The first is right-justified with 18-bit words, where the word ends exactly at each word-select edge. The second is I2S with 16-bit words, which are presented left-aligned in the 18-bit outputs.

All logic runs on the master clock `clk`. The three serial inputs pass through a synchronizer before use. The bit clock can come from the `sclk_in` pin. It can also be generated inside the block, in which case the block measures how many master clocks fit in one word-select period (256, 384 or 512). From that ratio and the selected framing it picks the bit clock multiple, and it drives the generated bit clock on `sclk_out` so that the upstream source can shift data with it.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `left_out`, `right_out`, `sample_valid` and `sclk_out` are all 0.
- R2: With `use_ext_sclk` = 1, a data bit is taken only on a rising edge of `sclk_in`, and the most significant bit comes first.
- R3: With `fmt_i2s` = 0 (right-justified), the left word is sent while `lrck_in` is high and the right word while it is low. The word is made of the last 18 bits received before each `lrck_in` edge, and any earlier bits in that half-period are discarded.
- R4: In right-justified framing, a half-period with fewer than 18 bit clock rising edges produces no word and no `sample_valid`.
- R5: With `fmt_i2s` = 1, the left word is sent while `lrck_in` is low and the right word while it is high. The MSB comes in the second bit slot after the `lrck_in` edge, and 16 bits are taken. The output is the 16-bit word followed by two 0 bits, and any further bits in the half-period are ignored.
- R6: With `use_ext_sclk` = 0, the block counts `clk` cycles per `lrck_in` period and accepts 256, 384 or 512. The bit clock multiple is then as follows: 64, 48 or 64 × Fs for right-justified framing, and 32, 48 or 32 × Fs for I2S. `sclk_out` shows exactly that many rising edges per `lrck_in` period, and data is sampled at those edges.
- R7: `sample_valid` pulses once for each frame, after the right word completes, and `left_out` and `right_out` update together in that cycle. At all other times both outputs hold their values.
- R8: `sample_valid` rises no more than 6 `clk` cycles after the last bit of the right word has been presented. For right-justified framing this is the `lrck_in` edge. For I2S it is the middle of the 16th data bit.
- R9: With `use_ext_sclk` = 0 and no legal ratio measured yet, `sclk_out` stays low and no samples are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select: 0 right-justified 18-bit, 1 I2S 16-bit |
| use_ext_sclk | input | 1 | Bit clock source: 1 takes `sclk_in`, 0 generates it internally |
| lrck_in | input | 1 | Word-select line; its frequency is the sample rate |
| sclk_in | input | 1 | External bit clock |
| sdata_in | input | 1 | Serial data, MSB first |
| sclk_out | output | 1 | Generated bit clock (low in external mode) |
| left_out | output | 18 | Left sample, signed |
| right_out | output | 18 | Right sample, signed |
| sample_valid | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
An input change reaches the logic after two synchronizer stages. A right-justified word is registered one cycle after the internal edge detect, and the output pair one cycle after that. `sample_valid` therefore appears 4 cycles after the `lrck_in` edge is driven. For I2S it appears 4 cycles after the bit clock rises in the middle of the 16th data bit. As it drives each completing edge or bit, the driver records a deadline 6 cycles later. The monitor, sampling on the falling clock edge, checks every strobe against both the expected word pair and that deadline. `sclk_out` rising edges are counted over whole frames, which is independent of the small phase lag behind the `lrck_in` edges.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int DIV_W = 5;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;

  // master clock cycles per serial bit, by detected ratio and framing
  function automatic logic [DIV_W-1:0] bit_period(input ratio_e r, input logic i2s);
    logic [DIV_W-1:0] d;
    case (r)
      RATIO_256: d = i2s ? DIV_W'(8) : DIV_W'(4);
      RATIO_384: d = DIV_W'(8);
      RATIO_512: d = i2s ? DIV_W'(16) : DIV_W'(8);
      default:   d = DIV_W'(8);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sad_ratio_det.sv
module sad_ratio_det
  import sad_pkg::*;
#(
  parameter int BASE_RATIO = 256
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   lr_rise,
  output ratio_e ratio,
  output logic   locked
);

  localparam int R_LO  = BASE_RATIO;
  localparam int R_MID = (BASE_RATIO * 3) / 2;
  localparam int R_HI  = BASE_RATIO * 2;
  localparam int CNT_W = $clog2(R_HI) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] meas;
  logic             seen;

  assign meas = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      seen   <= 1'b0;
      ratio  <= RATIO_NONE;
      locked <= 1'b0;
    end else if (lr_rise) begin
      cnt  <= '0;
      seen <= 1'b1;
      if (seen) begin
        if (meas == CNT_W'(R_LO)) begin
          ratio  <= RATIO_256;
          locked <= 1'b1;
        end else if (meas == CNT_W'(R_MID)) begin
          ratio  <= RATIO_384;
          locked <= 1'b1;
        end else if (meas == CNT_W'(R_HI)) begin
          ratio  <= RATIO_512;
          locked <= 1'b1;
        end else begin
          ratio  <= RATIO_NONE;
          locked <= 1'b0;
        end
      end
    end else if (cnt != '1) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_LOCK_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(lr_rise)); // R6

endmodule

// File: rtl/sad_bitclk.sv
module sad_bitclk
  import sad_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ext_mode,
  input  logic   i2s,
  input  logic   locked,
  input  ratio_e ratio,
  input  logic   lr_edge,
  input  logic   sclk_rise,
  output logic   tick,
  output logic   sclk_q
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] phase;
  logic             in_high;

  assign div  = bit_period(ratio, i2s);
  assign half = div >> 1;

  // phase restarts at every word-select edge so bit slots line up with it
  always_ff @(posedge clk) begin
    if (rst || lr_edge) begin
      phase <= '0;
    end else if (phase >= div - DIV_W'(1)) begin
      phase <= '0;
    end else begin
      phase <= phase + DIV_W'(1);
    end
  end

  assign in_high = (phase >= half - DIV_W'(1)) && (phase < div - DIV_W'(1));

  assign tick = ext_mode ? sclk_rise : (locked && (phase == half - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= !ext_mode && locked && in_high;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R6

  AST_SCLK_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && !locked) |=> !sclk_q); // R9

endmodule

// File: rtl/sad_frame_rx.sv
module sad_frame_rx #(
  parameter int LONG_W  = 18,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i2s,
  input  logic              tick,
  input  logic              sd,
  input  logic              lr_edge,
  input  logic              lr_lvl,
  output logic              word_valid,
  output logic              word_right,
  output logic [LONG_W-1:0] word
);

  localparam int NB_W  = $clog2(LONG_W + 1);
  localparam int GOT_W = $clog2(SHORT_W);
  localparam int PAD_W = LONG_W - SHORT_W;

  logic [LONG_W-1:0] shreg;
  logic [NB_W-1:0]   nbits;
  logic [GOT_W-1:0]  got;
  logic              skip_pend;
  logic              active;
  logic              act_right;
  logic              next_right;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      nbits      <= '0;
      got        <= '0;
      skip_pend  <= 1'b0;
      active     <= 1'b0;
      act_right  <= 1'b0;
      next_right <= 1'b0;
      word_valid <= 1'b0;
      word_right <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!i2s) begin
        // right-justified: keep the newest LONG_W bits, release at the edge
        active    <= 1'b0;
        skip_pend <= 1'b0;
        if (lr_edge) begin
          if (nbits == NB_W'(LONG_W)) begin
            word_valid <= 1'b1;
            word       <= shreg;
            word_right <= lr_lvl;   // rising edge ends the low (right) half
          end
          nbits <= '0;
        end else if (tick) begin
          shreg <= {shreg[LONG_W-2:0], sd};
          if (nbits != NB_W'(LONG_W)) begin
            nbits <= nbits + NB_W'(1);
          end
        end
      end else begin
        // I2S: skip one slot after the edge, then take SHORT_W bits
        nbits <= '0;
        if (lr_edge) begin
          skip_pend  <= 1'b1;
          next_right <= lr_lvl;     // high level carries the right word
        end else if (tick) begin
          if (active) begin
            shreg <= {shreg[LONG_W-2:0], sd};
            if (got == GOT_W'(SHORT_W - 1)) begin
              word_valid <= 1'b1;
              word_right <= act_right;
              word       <= {shreg[SHORT_W-2:0], sd, {PAD_W{1'b0}}};
              active     <= 1'b0;
            end else begin
              got <= got + GOT_W'(1);
            end
          end
          if (skip_pend) begin
            skip_pend <= 1'b0;
            active    <= 1'b1;
            got       <= '0;
            act_right <= next_right;
          end
        end
      end
    end
  end

  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R7

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import sad_pkg::*;
#(
  parameter int SAMPLE_W    = 18,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_RATIO  = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fmt_i2s,
  input  logic                use_ext_sclk,
  input  logic                lrck_in,
  input  logic                sclk_in,
  input  logic                sdata_in,
  output logic                sclk_out,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid
);

  localparam int N_IN = 3;
  localparam int TOP  = SYNC_STAGES - 1;

  logic [N_IN-1:0]                  raw;
  logic [N_IN-1:0][SYNC_STAGES-1:0] sync_q;
  logic                             lr_s, sc_s, sd_s;
  logic                             lr_d, sc_d;
  logic                             lr_edge, lr_rise, sclk_rise;

  assign raw = {lrck_in, sclk_in, sdata_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      lr_d   <= 1'b0;
      sc_d   <= 1'b0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        sync_q[i] <= {sync_q[i][SYNC_STAGES-2:0], raw[i]};
      end
      lr_d <= lr_s;
      sc_d <= sc_s;
    end
  end

  assign lr_s      = sync_q[2][TOP];
  assign sc_s      = sync_q[1][TOP];
  assign sd_s      = sync_q[0][TOP];
  assign lr_edge   = lr_s ^ lr_d;
  assign lr_rise   = lr_s & ~lr_d;
  assign sclk_rise = sc_s & ~sc_d;

  ratio_e              ratio;
  logic                locked;
  logic                tick;
  logic                word_valid, word_right;
  logic [SAMPLE_W-1:0] word;

  sad_ratio_det #(.BASE_RATIO(BASE_RATIO)) u_ratio (
    .clk     (clk),
    .rst     (rst),
    .lr_rise (lr_rise),
    .ratio   (ratio),
    .locked  (locked)
  );

  sad_bitclk u_bitclk (
    .clk       (clk),
    .rst       (rst),
    .ext_mode  (use_ext_sclk),
    .i2s       (fmt_i2s),
    .locked    (locked),
    .ratio     (ratio),
    .lr_edge   (lr_edge),
    .sclk_rise (sclk_rise),
    .tick      (tick),
    .sclk_q    (sclk_out)
  );

  sad_frame_rx #(.LONG_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .i2s        (fmt_i2s),
    .tick       (tick),
    .sd         (sd_s),
    .lr_edge    (lr_edge),
    .lr_lvl     (lr_s),
    .word_valid (word_valid),
    .word_right (word_right),
    .word       (word)
  );

  logic [SAMPLE_W-1:0] left_hold;
  logic                left_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold    <= '0;
      left_ok      <= 1'b0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (word_valid) begin
        if (!word_right) begin
          left_hold <= word;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_out     <= left_hold;
          right_out    <= word;
          sample_valid <= 1'b1;
          left_ok      <= 1'b0;
        end
      end
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(left_out) && $stable(right_out))); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid); // R7

endmodule

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;

  logic        clk = 1'b0;
  logic        rst;
  logic        fmt_i2s, use_ext_sclk, lrck_in, sclk_in, sdata_in;
  logic        sclk_out, sample_valid;
  logic [17:0] left_out, right_out;

  always #4 clk = ~clk;

  audio_serial_rx u0 (
    .clk          (clk),
    .rst          (rst),
    .fmt_i2s      (fmt_i2s),
    .use_ext_sclk (use_ext_sclk),
    .lrck_in      (lrck_in),
    .sclk_in      (sclk_in),
    .sdata_in     (sdata_in),
    .sclk_out     (sclk_out),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

  int          cyc = 0;
  int          tests = 0;
  int          fails = 0;
  int          vcount = 0;
  bit          armed = 0;
  bit          pend_right = 0;
  bit          done = 0;
  logic        prev_lsb = 1'b0;
  string       cur_tag = "R1";
  logic [17:0] exp_l[$];
  logic [17:0] exp_r[$];
  int          due_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && sample_valid) begin
      vcount++;
      if (exp_l.size() > 0) begin
        logic [17:0] el, er;
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        chk(left_out == el, cur_tag, "left word", left_out, el);
        chk(right_out == er, cur_tag, "right word", right_out, er);
        if (due_q.size() > 0) begin
          int d;
          d = due_q.pop_front();
          chk(cyc <= d, "R8", "valid cycle vs deadline", cyc, d);
        end else begin
          chk(1'b0, "R8", "valid before right word completed", cyc, 0);
        end
      end else if (armed) begin
        chk(1'b0, "R7", "unexpected sample_valid", 1, 0);
      end
    end
  end

  // one word-select period: first half carries left, second right
  task automatic frame(input int S, input int D, input bit data, input bit arm,
                       input logic [17:0] l, input logic [17:0] r);
    int          fc;
    int          rises;
    logic        ps;
    logic        lvl;
    logic        b;
    logic [17:0] w18;
    logic [15:0] w16;
    int          add_due;
    fc    = 0;
    rises = 0;
    ps    = sclk_out;
    for (int h = 0; h < 2; h++) begin
      lvl = fmt_i2s ? (h == 1) : (h == 0);
      w18 = (h == 0) ? l : r;
      w16 = w18[17:2];
      if (h == 1 && data) begin
        exp_l.push_back(fmt_i2s ? {l[17:2], 2'b00} : l);
        exp_r.push_back(fmt_i2s ? {r[17:2], 2'b00} : r);
      end
      for (int s = 0; s < S; s++) begin
        add_due = -1;
        if (!fmt_i2s) begin
          if (s >= S - 18) b = w18[17 - (s - (S - 18))];
          else b = 1'b1;
          if (h == 0 && s == 0 && pend_right) begin add_due = 6; pend_right = 0; end
          if (h == 1 && s == 0) pend_right = data;
        end else begin
          if (s == 0) b = (S == 16) ? prev_lsb : 1'b1;
          else if (s <= 16) b = w16[16 - s];
          else b = 1'b1;
          if (S > 16 && h == 1 && s == 16 && data) add_due = D / 2 + 6;
          if (S == 16 && h == 0 && s == 0 && pend_right) begin
            add_due = D / 2 + 6;
            pend_right = 0;
          end
          if (S == 16 && h == 1 && s == 0) pend_right = data;
        end
        for (int c = 0; c < D; c++) begin
          @(negedge clk);
          lrck_in  = lvl;
          sdata_in = b;
          sclk_in  = use_ext_sclk && (c >= D / 2);
          if (c == 0 && add_due >= 0) due_q.push_back(cyc + add_due);
          if (arm && fc == 32) armed = 1;
          if (sclk_out && !ps) rises++;
          ps = sclk_out;
          fc++;
        end
      end
      if (fmt_i2s) prev_lsb = w16[0];
    end
    if (data && !use_ext_sclk)
      chk(rises == 2 * S, "R6", "sclk_out rises per period", rises, 2 * S);
  endtask

  task automatic run_case(input string tag, input logic fmt, input logic ext,
                          input int S, input int D, input bit words);
    int v0;
    fmt_i2s      = fmt;
    use_ext_sclk = ext;
    cur_tag      = tag;
    armed        = 0;
    pend_right   = 0;
    for (int k = 0; k < 4; k++) frame(S, D, 0, 0, 18'h0, 18'h0);
    v0 = vcount;
    for (int k = 0; k < 3; k++) begin
      logic [17:0] l, r;
      l = 18'($urandom);
      r = 18'($urandom);
      frame(S, D, words, (k == 0), l, r);
    end
    if (!words) chk(vcount == v0, "R4", "valid count on short halves", vcount - v0, 0);
    armed = 0;
    frame(S, D, 0, 0, 18'h0, 18'h0);
    repeat (20) @(negedge clk);
    chk(exp_l.size() == 0 && due_q.size() == 0, "R7", "pairs left unmatched",
        exp_l.size(), 0);
    exp_l.delete();
    exp_r.delete();
    due_q.delete();
    pend_right = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    rst          = 1'b1;
    fmt_i2s      = 1'b0;
    use_ext_sclk = 1'b0;
    lrck_in      = 1'b0;
    sclk_in      = 1'b0;
    sdata_in     = 1'b0;
    repeat (5) @(negedge clk);
    chk(left_out == 0, "R1", "left_out in reset", left_out, 0);
    chk(sample_valid == 0, "R1", "sample_valid in reset", sample_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(left_out == 0 && right_out == 0, "R1", "outputs after reset",
        {left_out, right_out}, 0);
    chk(sclk_out == 0, "R1", "sclk_out after reset", sclk_out, 0);

    hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sclk_out || sample_valid) hi++;
    end
    chk(hi == 0, "R9", "activity before ratio lock", hi, 0);

    run_case("R3", 1'b0, 1'b0, 32, 4,  1);  // 256 ratio, 64 Fs
    run_case("R3", 1'b0, 1'b0, 24, 8,  1);  // 384 ratio, 48 Fs
    run_case("R3", 1'b0, 1'b0, 32, 8,  1);  // 512 ratio, 64 Fs
    run_case("R5", 1'b1, 1'b0, 16, 8,  1);  // 256 ratio, 32 Fs
    run_case("R5", 1'b1, 1'b0, 24, 8,  1);  // 384 ratio, 48 Fs
    run_case("R5", 1'b1, 1'b0, 16, 16, 1);  // 512 ratio, 32 Fs
    run_case("R2", 1'b0, 1'b1, 18, 8,  1);  // external, 36 bits per period
    run_case("R2", 1'b0, 1'b1, 32, 4,  1);  // external, leading bits discarded
    run_case("R2", 1'b1, 1'b1, 32, 4,  1);  // external I2S, trailing bits ignored
    run_case("R2", 1'b1, 1'b1, 16, 8,  1);  // external I2S, LSB in next half
    run_case("R4", 1'b0, 1'b1, 16, 8,  0);  // too few bits per half

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule